// File: doc/BRIEF.md
# Per-Core Stall Watchdog

This block watches one processor core for forward progress and raises a hang interrupt when the core stops making it. Software picks one of the core's performance event lines (for example load retired, store retired or instruction retired) to serve as the heartbeat. It also sets a threshold in units of a fixed 10 ns tick. The block counts tick intervals in which the chosen event never fired. Any heartbeat clears that count. When the count reaches the threshold, the interrupt goes high and stays high. A secure watchdog elsewhere on the chip can take it from there and reset the system.

One instance serves one core, and each instance has its own configuration and threshold registers behind a plain write/read port. The read data is combinational from the address. The tick is a one-cycle enable produced every `TICK_DIV` clocks. An integrator sets `TICK_DIV` to the number of clock cycles in 10 ns. Every write to the configuration or threshold register restarts the tick phase and the count. This means reprogramming can never cause a false trigger. There is no data stream, so no valid/ready handshake is involved. Every pin is a plain control or status signal.

Register map (word address on `reg_addr`):
- Address 0, control: bit 0 is the enable, bit 1 is a write-one interrupt clear (it always reads 0), and bits [8 +: SEL_W] hold the event select (the index into `core_evt`).
- Address 1, threshold: bits [THR_W-1:0].
- Any other address reads 0 and ignores writes.

Top module: `core_stall_watch`

## Requirements
- R1: After reset, `hang_irq` is 0 and both the control and threshold registers read 0.
- R2: The enable bit and the select field read back at address 0 as written, with bit 1 (clear) always reading 0. The threshold reads back at address 1. Other addresses read 0 and writes to them change nothing.
- R3: With detection enabled and no selected event, `hang_irq` rises exactly THRESHOLD×TICK_DIV clock edges after the edge that took the enabling write. It is still low one edge earlier.
- R4: A pulse on the selected event line zeroes the count, and the tick interval that contains it is not counted. For an event taken at edge k after a restart at edge 0, the interrupt rises at edge (ceil(k/TICK_DIV)+THRESHOLD)×TICK_DIV.
- R5: Pulses on event lines other than the selected one have no effect on the timeout.
- R6: Once high, `hang_irq` stays high, even across heartbeats, until it is cleared or detection stops. The count saturates at the threshold instead of wrapping.
- R7: A control write with bit 1 set drops `hang_irq` at that write's edge and restarts the count. A new interrupt then rises THRESHOLD×TICK_DIV edges later.
- R8: While the enable bit is 0, the count is held at zero and `hang_irq` stays low. Disabling drops a raised interrupt one edge after the disabling write.
- R9: Writing the threshold or the control register restarts the tick phase and the count. The next timeout is measured from that write with the new settings.
- R10: A threshold of 0 acts as detection disabled: no interrupt, and a raised interrupt drops one edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from `reg_addr` |
| core_evt | input | NUM_EVT | Per-cycle performance event pulses from the core |
| hang_irq | output | 1 | Hang interrupt, sticky |

## Verification
Some properties are checked every cycle:
- The count never passes the threshold.
- A selected event, and any control or threshold write, zero the count.
- An interrupt rises only with the count at the threshold.
- The interrupt holds between writes while detection runs.
- A clear write, a disabled state or a zero threshold leave it low.

Other behaviour needs the bench's scenarios:
- The exact rise edges for the event-free timeout, for an event on a tick boundary, for an event inside an interval, after a clear, and after reprogramming the threshold or the select.
- The absence of any effect from unselected lines.
- Register readback.

// File: rtl/csw_pkg.sv
package csw_pkg;
  // register word addresses
  localparam int CTRL_ADDR = 0;
  localparam int THR_ADDR  = 1;
  // control register bit positions
  localparam int EN_BIT    = 0;
  localparam int CLR_BIT   = 1;
  localparam int SEL_LSB   = 8;
endpackage

// File: rtl/csw_regs.sv
module csw_regs
  import csw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int THR_W  = 16,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              en_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic [THR_W-1:0]  thr_q,
  output logic              restart,
  output logic              clr
);
  logic wr_ctrl, wr_thr;
  logic unused_wdata;

  assign wr_ctrl = we && (addr == ADDR_W'(CTRL_ADDR));
  assign wr_thr  = we && (addr == ADDR_W'(THR_ADDR));
  assign restart = wr_ctrl || wr_thr;
  assign clr     = wr_ctrl && wdata[CLR_BIT];
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
      thr_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata[EN_BIT];
        sel_q <= wdata[SEL_LSB +: SEL_W];
      end
      if (wr_thr) thr_q <= wdata[THR_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(CTRL_ADDR)) begin
      rdata[EN_BIT]            = en_q;
      rdata[SEL_LSB +: SEL_W]  = sel_q;
    end else if (addr == ADDR_W'(THR_ADDR)) begin
      rdata[THR_W-1:0] = thr_q;
    end
  end
endmodule

// File: rtl/csw_tick_gen.sv
module csw_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = run;
    end else begin : g_div
      localparam int DIV_W = $clog2(TICK_DIV);
      localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);
      logic [DIV_W-1:0] phase;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            phase <= '0;
        else if (!run)         phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                   phase <= phase + 1'b1;
      end

      assign tick = run && (phase == LAST);
    end
  endgenerate
endmodule

// File: rtl/csw_evt_sel.sv
module csw_evt_sel #(
  parameter int NUM_EVT = 4,
  parameter int SEL_W   = 2
) (
  input  logic [NUM_EVT-1:0] evt,
  input  logic [SEL_W-1:0]   sel,
  output logic               hit
);
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (sel == SEL_W'(i)) hit = evt[i];
    end
  end
endmodule

// File: rtl/csw_stall_ctr.sv
module csw_stall_ctr #(
  parameter int THR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             restart,
  input  logic             clr,
  input  logic             tick,
  input  logic             hit,
  input  logic [THR_W-1:0] thr,
  output logic [THR_W-1:0] cnt,
  output logic             irq
);
  logic             seen;
  logic [THR_W-1:0] cnt_inc;

  // saturating increment: holds once the threshold is reached
  assign cnt_inc = (cnt >= thr) ? cnt : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      seen <= 1'b0;
      irq  <= 1'b0;
    end else if (!active) begin
      cnt  <= '0;
      seen <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (clr) irq <= 1'b0;
      if (restart) begin
        cnt  <= '0;
        seen <= 1'b0;
      end else if (tick) begin
        seen <= 1'b0;
        if (seen || hit) begin
          cnt <= '0;
        end else begin
          cnt <= cnt_inc;
          if (cnt_inc >= thr) irq <= 1'b1;
        end
      end else if (hit) begin
        cnt  <= '0;
        seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/core_stall_watch.sv
module core_stall_watch #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2,
  parameter int THR_W    = 16,
  parameter int NUM_EVT  = 4,
  parameter int TICK_DIV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_EVT-1:0] core_evt,
  output logic               hang_irq
);
  localparam int SEL_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic             en_q, restart, clr, tick, evt_hit, active;
  logic [SEL_W-1:0] sel_q;
  logic [THR_W-1:0] thr_q, stall_cnt;

  csw_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .THR_W(THR_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .en_q(en_q), .sel_q(sel_q), .thr_q(thr_q),
    .restart(restart), .clr(clr)
  );

  assign active = en_q && (thr_q != '0);

  csw_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(active && !restart), .tick(tick)
  );

  csw_evt_sel #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_sel (
    .evt(core_evt), .sel(sel_q), .hit(evt_hit)
  );

  csw_stall_ctr #(.THR_W(THR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .active(active), .restart(restart), .clr(clr),
    .tick(tick), .hit(evt_hit), .thr(thr_q), .cnt(stall_cnt), .irq(hang_irq)
  );
endmodule

// File: rtl/csw_checker.sv
module csw_checker
  import csw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int THR_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              hang_irq,
  input logic              active,
  input logic              evt_hit,
  input logic [THR_W-1:0]  stall_cnt,
  input logic [THR_W-1:0]  thr
);
  logic ctrl_wr, any_wr;
  assign ctrl_wr = reg_we && (reg_addr == ADDR_W'(CTRL_ADDR));
  assign any_wr  = ctrl_wr || (reg_we && (reg_addr == ADDR_W'(THR_ADDR)));

  p_rise_at_thr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hang_irq) |-> (active && stall_cnt == thr));

  p_evt_zeroes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && evt_hit && !reg_we) |=> (stall_cnt == '0));

  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hang_irq && active && !reg_we) |=> hang_irq);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (stall_cnt <= thr));

  p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && reg_wdata[CLR_BIT]) |=> !hang_irq);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!hang_irq && stall_cnt == '0));

  p_reprog_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr |=> (stall_cnt == '0));

  p_zero_thr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == '0) |=> !hang_irq);
endmodule

bind core_stall_watch csw_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .THR_W(THR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .hang_irq(hang_irq), .active(active), .evt_hit(evt_hit), .stall_cnt(stall_cnt), .thr(thr_q)
);

// File: tb/sim_core_stall_watch.sv
module sim_core_stall_watch;
  localparam int D = 4, NE = 4, TW = 16, AW = 2, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NE-1:0] evt = '0;
  logic          irq;

  core_stall_watch #(.DATA_W(DW), .ADDR_W(AW), .THR_W(TW), .NUM_EVT(NE), .TICK_DIV(D)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .core_evt(evt), .hang_irq(irq)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct { int at; string tag; } exp_t;
  exp_t sb[$];

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // monitor: every rising edge of the interrupt is matched against the scoreboard
  logic prev_irq = 1'b0;
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n && irq && !prev_irq) begin
      if (sb.size() == 0) check(1'b0, "R6", "unexpected hang_irq rise at cycle", cyc, -1);
      else begin
        e = sb.pop_front();
        check(cyc == e.at, e.tag, "hang_irq rise cycle", cyc, e.at);
      end
    end
    prev_irq = irq;
  end

  task automatic expect_rise(int at, string tag);
    sb.delete();
    sb.push_back('{at, tag});
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d, output int e);
    @(negedge clk);
    we = 1'b1; addr = AW'(a); wdata = d;
    e = cyc + 1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = AW'(a);
    #1 d = rdata;
  endtask

  task automatic pulse(input int line, output int k);
    @(negedge clk);
    evt[line] = 1'b1;
    k = cyc + 1;
    @(negedge clk);
    evt[line] = 1'b0;
  endtask

  task automatic drain(int maxc, string tag);
    int n = 0;
    while (sb.size() != 0 && n < maxc) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    check(sb.size() == 0, tag, "expected rises still pending", sb.size(), 0);
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : drv
    int e0, e1, e2, k;
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check(irq == 1'b0, "R1", "hang_irq after reset", irq, 0);
    rd(0, d); check(d == 0, "R1", "control after reset", d, 0);
    rd(1, d); check(d == 0, "R1", "threshold after reset", d, 0);

    // R2 threshold readback, R8 disabled stays quiet
    wr(1, 5, e0);
    rd(1, d); check(d == 5, "R2", "threshold readback", d, 5);
    check(irq == 1'b0, "R8", "hang_irq while disabled", irq, 0);

    // R3 plain timeout, select 0
    wr(0, 32'h1, e0);
    expect_rise(e0 + 5 * D, "R3");
    repeat (5 * D - 1) @(negedge clk);
    check(irq == 1'b0, "R3", "hang_irq one edge before timeout", irq, 0);
    drain(50, "R3");
    rd(0, d); check(d == 1, "R2", "control readback", d, 1);

    // R6 sticky through a heartbeat
    pulse(0, k);
    repeat (30) @(negedge clk);
    check(irq == 1'b1, "R6", "hang_irq held after heartbeat", irq, 1);

    // R7 clear restarts
    wr(0, 32'h3, e1);
    check(irq == 1'b0, "R7", "hang_irq after clear write", irq, 0);
    expect_rise(e1 + 5 * D, "R7");
    drain(50, "R7");
    rd(0, d); check(d == 1, "R2", "clear bit reads zero", d, 1);

    // R8 disable
    wr(0, 32'h0, e0);
    @(negedge clk);
    check(irq == 1'b0, "R8", "hang_irq after disable", irq, 0);
    repeat (100) @(negedge clk);
    check(irq == 1'b0, "R8", "hang_irq stays low while disabled", irq, 0);

    // R4 event on a tick boundary, select 2, threshold 3
    wr(1, 3, e0);
    wr(0, 32'h201, e0);
    repeat (6) @(negedge clk);
    pulse(2, k);
    check(k - e0 == 8, "R4", "event edge offset", k - e0, 8);
    expect_rise(e0 + ((k - e0 + D - 1) / D + 3) * D, "R4");
    drain(60, "R4");

    // R4 event inside an interval
    wr(0, 32'h203, e0);
    @(negedge clk);
    pulse(2, k);
    expect_rise(e0 + ((k - e0 + D - 1) / D + 3) * D, "R4");
    drain(60, "R4");

    // R5 unselected lines ignored
    wr(0, 32'h203, e1);
    expect_rise(e1 + 3 * D, "R5");
    evt = 4'b1011;
    repeat (10) @(negedge clk);
    evt = '0;
    drain(40, "R5");

    // R9 reprogram threshold, then select
    wr(0, 32'h203, e0);
    expect_rise(e0 + 3 * D, "R9");
    repeat (5) @(negedge clk);
    wr(1, 6, e2);
    expect_rise(e2 + 6 * D, "R9");
    repeat (9) @(negedge clk);
    wr(0, 32'h101, e1);
    expect_rise(e1 + 6 * D, "R9");
    drain(60, "R9");
    rd(0, d); check(d == 32'h101, "R2", "select readback", d, 32'h101);

    // R10 zero threshold disables
    wr(1, 0, e0);
    @(negedge clk);
    check(irq == 1'b0, "R10", "hang_irq after zero threshold", irq, 0);
    repeat (150) @(negedge clk);
    check(irq == 1'b0, "R10", "hang_irq stays low with zero threshold", irq, 0);

    // R2 unused address
    wr(3, 32'hFFFF_FFFF, e0);
    rd(3, d); check(d == 0, "R2", "unused address read", d, 0);
    rd(1, d); check(d == 0, "R2", "threshold after unused write", d, 0);
    rd(0, d); check(d == 32'h101, "R2", "control after unused write", d, 32'h101);

    check(sb.size() == 0, "R3", "scoreboard empty at end", sb.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule